// File: doc/BRIEF.md
# Audio Silence Detector with Automatic Mute

This block watches a stream of unsigned audio amplitude samples and decides when the input has gone quiet and when it has come back. Time is measured in windows built from an external 1 ms tick. At the end of each window the block counts how many samples rose above a low amplitude level. If that count falls short of a programmed minimum, the block raises a mute request and a silence flag.

While muted, a second, higher amplitude level and a second, larger event count govern recovery. As soon as enough loud samples have been seen within the current window, the block releases the mute. It does not wait for the window to end. The separate levels and counts give the detector hysteresis, so a signal hovering near one level does not toggle the mute.

All settings are 3-bit codes on input ports. A single enable turns detection on. With the enable low, the block is idle and unmuted.

Top module: `quiet_guard`

## Requirements
- R1: Reset leaves both outputs at 0. While `det_en` is 0, the window timer and both counters are held at zero, and both outputs are 0 one cycle after `det_en` is sampled low.
- R2: The window code sets the window length in ticks of `tick_ms`:
  - codes 0 to 3 give 50, 100, 200 and 400;
  - codes 4 to 7 give 1000, 2000, 4000 and 8000.
  
  A window ends on the clock cycle that carries its last tick. The timer advances only on cycles where `tick_ms` is 1.
- R3: Amplitude levels use 1 LSB per 0.25 mV. The low level is 1<<code and the high level is 2<<code. A sample counts only when `smp_valid` is 1 and its amplitude is strictly greater than the level.
- R4: The low event minimum is 1<<code (1 to 128). The high event limit is (16<<code)-1 (15 to 2047).
- R5: Entry into mute: at the end of a window, when not muted and the low count is below the low minimum, the mute request goes to 1 on the next clock edge. The low count used is the count of samples before the final cycle of the window.
- R6: Exit from mute: while muted, once the high count exceeds the high limit, the mute request returns to 0 on the following edge. This happens at any point in the window.
- R7: Both counters restart at each window boundary. A sample in the cycle that ends a window counts toward the new window. Counters saturate and never wrap.
- R8: `silence_flag` is 1 exactly while silence is detected. It equals `mute_req` and clears when mute is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | Detection enable |
| smp_valid | input | 1 | Amplitude sample strobe |
| smp_amp | input | AMP_W | Unsigned amplitude, 0.25 mV per LSB |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| win_code | input | 3 | Window length code |
| lo_amp_code | input | 3 | Low amplitude level code |
| hi_amp_code | input | 3 | High amplitude level code |
| lo_cnt_code | input | 3 | Low event minimum code |
| hi_cnt_code | input | 3 | High event limit code |
| mute_req | output | 1 | Automatic mute request |
| silence_flag | output | 1 | Silence detected status |

## Verification
The bench sets amplitudes exactly at each level and one LSB above it. A design using >= instead of > would mute one window too late or release early.

It places counts exactly at the low minimum and at the high limit. An off-by-one comparison moves the mute edge by one window or by one sample.

It puts a loud sample on the cycle that ends a window and checks that the sample lands in the next window. It drives 300 events against a 128 minimum, where an 8-bit counter that wraps instead of saturating would wrongly mute.

It checks that release happens mid-window, with no wait for a tick. Long random runs with changing codes are compared cycle by cycle against a model built from bench tables.

// File: rtl/quiet_guard_pkg.sv
package quiet_guard_pkg;

  // Longest window in ticks and largest event thresholds
  localparam int WIN_MAX_MS = 8000;
  localparam int LO_NEED_MAX = 128;
  localparam int HI_LIMIT_MAX = 2047;

  localparam int WIN_W = $clog2(WIN_MAX_MS + 1);
  localparam int LO_W = $clog2(LO_NEED_MAX + 1);
  localparam int HI_W = $clog2(HI_LIMIT_MAX + 2);

  typedef enum logic {
    ST_LIVE = 1'b0,
    ST_QUIET = 1'b1
  } qg_state_e;

  // Window length in ms: short ladder from 50, long ladder from 1000
  function automatic int window_ms(input logic [2:0] code);
    if (code[2]) begin
      return 1000 << code[1:0];
    end
    return 50 << code[1:0];
  endfunction

  function automatic int lo_amp_level(input logic [2:0] code);
    return 1 << code;
  endfunction

  function automatic int hi_amp_level(input logic [2:0] code);
    return 2 << code;
  endfunction

  function automatic int lo_need(input logic [2:0] code);
    return 1 << code;
  endfunction

  function automatic int hi_limit(input logic [2:0] code);
    return (16 << code) - 1;
  endfunction

endpackage

// File: rtl/qg_window_timer.sv
module qg_window_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic last_tick;

  assign last_tick = (cnt_q >= (len - W'(1)));
  assign wrap = en && tick && last_tick;
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= last_tick ? '0 : cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/qg_event_counter.sv
module qg_event_counter #(
  parameter int AMP_W = 16,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             vld,
  input  logic [AMP_W-1:0] amp,
  input  logic [AMP_W-1:0] thr,
  output logic [CW-1:0]    cnt
);

  logic [CW-1:0] cnt_q;
  logic hit;
  logic full;

  assign hit = en && vld && (amp > thr);
  assign full = &cnt_q;
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (clr) begin
      // boundary sample opens the new window
      cnt_q <= hit ? CW'(1) : '0;
    end else if (hit && !full) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/qg_mute_fsm.sv
module qg_mute_fsm
  import quiet_guard_pkg::*;
#(
  parameter int LW = 8,
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          win_end,
  input  logic [LW-1:0] lo_cnt,
  input  logic [LW-1:0] lo_min,
  input  logic [HW-1:0] hi_cnt,
  input  logic [HW-1:0] hi_max,
  output logic          muted
);

  qg_state_e st_q;
  qg_state_e st_d;
  logic go_quiet;
  logic go_live;

  assign go_quiet = win_end && (lo_cnt < lo_min);
  assign go_live = (hi_cnt > hi_max);

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = ST_LIVE;
    end else begin
      case (st_q)
        ST_LIVE: if (go_quiet) st_d = ST_QUIET;
        ST_QUIET: if (go_live) st_d = ST_LIVE;
        default: st_d = ST_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_LIVE;
    end else begin
      st_q <= st_d;
    end
  end

  assign muted = (st_q == ST_QUIET);

endmodule

// File: rtl/quiet_guard.sv
module quiet_guard
  import quiet_guard_pkg::*;
#(
  parameter int AMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic             smp_valid,
  input  logic [AMP_W-1:0] smp_amp,
  input  logic             tick_ms,
  input  logic [2:0]       win_code,
  input  logic [2:0]       lo_amp_code,
  input  logic [2:0]       hi_amp_code,
  input  logic [2:0]       lo_cnt_code,
  input  logic [2:0]       hi_cnt_code,
  output logic             mute_req,
  output logic             silence_flag
);

  logic [WIN_W-1:0] win_len;
  logic [WIN_W-1:0] win_cnt;
  logic win_end;
  logic [AMP_W-1:0] lo_thr;
  logic [AMP_W-1:0] hi_thr;
  logic [LO_W-1:0] lo_cnt;
  logic [LO_W-1:0] lo_min;
  logic [HI_W-1:0] hi_cnt;
  logic [HI_W-1:0] hi_max;
  logic muted;

  assign win_len = WIN_W'(window_ms(win_code));
  assign lo_thr = AMP_W'(lo_amp_level(lo_amp_code));
  assign hi_thr = AMP_W'(hi_amp_level(hi_amp_code));
  assign lo_min = LO_W'(lo_need(lo_cnt_code));
  assign hi_max = HI_W'(hi_limit(hi_cnt_code));

  qg_window_timer #(.W(WIN_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(det_en), .tick(tick_ms),
    .len(win_len), .cnt(win_cnt), .wrap(win_end)
  );

  qg_event_counter #(.AMP_W(AMP_W), .CW(LO_W)) u_lo_cnt (
    .clk(clk), .rst_n(rst_n), .en(det_en), .clr(win_end),
    .vld(smp_valid), .amp(smp_amp), .thr(lo_thr), .cnt(lo_cnt)
  );

  qg_event_counter #(.AMP_W(AMP_W), .CW(HI_W)) u_hi_cnt (
    .clk(clk), .rst_n(rst_n), .en(det_en), .clr(win_end),
    .vld(smp_valid), .amp(smp_amp), .thr(hi_thr), .cnt(hi_cnt)
  );

  qg_mute_fsm #(.LW(LO_W), .HW(HI_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(det_en), .win_end(win_end),
    .lo_cnt(lo_cnt), .lo_min(lo_min), .hi_cnt(hi_cnt), .hi_max(hi_max),
    .muted(muted)
  );

  assign mute_req = muted;
  assign silence_flag = muted;

endmodule

// File: rtl/quiet_guard_chk.sv
module quiet_guard_chk
  import quiet_guard_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             det_en,
  input logic             tick_ms,
  input logic [2:0]       hi_cnt_code,
  input logic             mute_req,
  input logic             win_end,
  input logic [WIN_W-1:0] win_cnt,
  input logic [LO_W-1:0]  lo_cnt,
  input logic [HI_W-1:0]  hi_cnt
);

  p_off_unmuted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !mute_req);

  p_timer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !tick_ms) |=> $stable(win_cnt));

  p_enter_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_req) |-> $past(win_end));

  p_exit_by_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mute_req) && $past(det_en)) |->
      (int'($past(hi_cnt)) > hi_limit($past(hi_cnt_code))));

  p_lo_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !win_end && lo_cnt != '0) |=> lo_cnt != '0);

  p_hi_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !win_end && hi_cnt != '0) |=> hi_cnt != '0);

endmodule

bind quiet_guard quiet_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .tick_ms(tick_ms),
  .hi_cnt_code(hi_cnt_code), .mute_req(mute_req), .win_end(win_end),
  .win_cnt(win_cnt), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
);

// File: tb/quiet_guard_bench.sv
module quiet_guard_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_en = 1'b0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_amp = '0;
  logic tick_ms = 1'b0;
  logic [2:0] win_code = '0;
  logic [2:0] lo_amp_code = '0;
  logic [2:0] hi_amp_code = '0;
  logic [2:0] lo_cnt_code = '0;
  logic [2:0] hi_cnt_code = '0;
  logic mute_req;
  logic silence_flag;

  int n_tests = 0;
  int n_fail = 0;

  // Bench model state
  int m_tmr = 0;
  int m_lo = 0;
  int m_hi = 0;
  bit m_mute = 1'b0;

  always #5 clk = ~clk;

  quiet_guard u_quiet_guard (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .smp_valid(smp_valid),
    .smp_amp(smp_amp), .tick_ms(tick_ms), .win_code(win_code),
    .lo_amp_code(lo_amp_code), .hi_amp_code(hi_amp_code),
    .lo_cnt_code(lo_cnt_code), .hi_cnt_code(hi_cnt_code),
    .mute_req(mute_req), .silence_flag(silence_flag)
  );

  function automatic int b_win(input logic [2:0] c);
    case (c)
      3'd0: return 50;
      3'd1: return 100;
      3'd2: return 200;
      3'd3: return 400;
      3'd4: return 1000;
      3'd5: return 2000;
      3'd6: return 4000;
      default: return 8000;
    endcase
  endfunction

  function automatic int b_pow2(input logic [2:0] c);
    int v = 1;
    for (int i = 0; i < int'(c); i++) v = v * 2;
    return v;
  endfunction

  function automatic int b_lo_lvl(input logic [2:0] c); return b_pow2(c); endfunction
  function automatic int b_hi_lvl(input logic [2:0] c); return 2 * b_pow2(c); endfunction
  function automatic int b_lo_min(input logic [2:0] c); return b_pow2(c); endfunction
  function automatic int b_hi_max(input logic [2:0] c); return 16 * b_pow2(c) - 1; endfunction

  task automatic model_edge();
    bit wend;
    bit hl;
    bit hh;
    bit nmute;
    wend = det_en && tick_ms && (m_tmr >= b_win(win_code) - 1);
    hl = det_en && smp_valid && (int'(smp_amp) > b_lo_lvl(lo_amp_code));
    hh = det_en && smp_valid && (int'(smp_amp) > b_hi_lvl(hi_amp_code));
    if (!det_en) nmute = 1'b0;
    else if (m_mute) nmute = !(m_hi > b_hi_max(hi_cnt_code));
    else nmute = wend && (m_lo < b_lo_min(lo_cnt_code));
    m_mute = nmute;
    if (!det_en) begin
      m_lo = 0; m_hi = 0; m_tmr = 0;
    end else begin
      if (wend) begin
        m_lo = hl ? 1 : 0;
        m_hi = hh ? 1 : 0;
      end else begin
        if (hl && m_lo < 255) m_lo++;
        if (hh && m_hi < 4095) m_hi++;
      end
      if (tick_ms) m_tmr = wend ? 0 : m_tmr + 1;
    end
  endtask

  task automatic step(input bit v, input logic [15:0] a, input bit tk);
    smp_valid = v;
    smp_amp = a;
    tick_ms = tk;
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " mute_req vs model"}, int'(mute_req), int'(m_mute));
    chk({tag, " silence_flag R8"}, int'(silence_flag), int'(m_mute));
  endtask

  task automatic restart();
    det_en = 1'b0;
    step(1'b0, '0, 1'b0);
    det_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset mute_req", int'(mute_req), 0);
    chk("R1 reset silence_flag", int'(silence_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: disabled, silent input for long time stays unmuted
    win_code = 3'd0; lo_cnt_code = 3'd2; lo_amp_code = 3'd3;
    for (int i = 0; i < 120; i++) step(1'b0, '0, 1'b1);
    chk("R1 disabled no mute", int'(mute_req), 0);

    // R3/R5: low level 8, minimum 4, window 50 ticks
    restart();
    for (int i = 0; i < 50; i++) step(i < 4, 16'd9, 1'b1);
    chk("R5 count at minimum stays live", int'(mute_req), 0);
    for (int i = 0; i < 50; i++) step(i < 4, (i == 3) ? 16'd8 : 16'd9, 1'b1);
    chk("R3 amp equal to level not counted -> mute", int'(mute_req), 1);
    chk("R8 flag set with mute", int'(silence_flag), 1);

    // R4/R6: high level 2, limit 15, release mid-window
    hi_amp_code = 3'd0; hi_cnt_code = 3'd0;
    for (int i = 0; i < 15; i++) step(1'b1, 16'd3, 1'b0);
    step(1'b1, 16'd2, 1'b0);
    step(1'b0, '0, 1'b0);
    chk("R4 limit reached but not exceeded", int'(mute_req), 1);
    step(1'b1, 16'd3, 1'b0);
    chk("R6 16th sample not yet seen", int'(mute_req), 1);
    step(1'b0, '0, 1'b0);
    chk("R6 release mid-window", int'(mute_req), 0);
    chk("R8 flag cleared on release", int'(silence_flag), 0);

    // R2: window code 1 = 100 ticks, silent input
    restart();
    win_code = 3'd1; lo_cnt_code = 3'd0;
    for (int i = 0; i < 99; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    chk("R2 no mute before last tick", int'(mute_req), 0);
    step(1'b0, '0, 1'b1);
    chk("R2 mute after 100th tick", int'(mute_req), 1);

    // R1: dropping enable releases at once
    det_en = 1'b0;
    step(1'b0, '0, 1'b0);
    chk("R1 enable low releases", int'(mute_req), 0);

    // R7: boundary sample counts into next window
    restart();
    win_code = 3'd0; lo_cnt_code = 3'd0; lo_amp_code = 3'd0; hi_cnt_code = 3'd7;
    for (int i = 0; i < 50; i++) step(i == 0 || i == 49, 16'd5, 1'b1);
    chk("R7 first window live", int'(mute_req), 0);
    for (int i = 0; i < 50; i++) step(1'b0, '0, 1'b1);
    chk("R7 boundary sample carried", int'(mute_req), 0);
    for (int i = 0; i < 50; i++) step(1'b0, '0, 1'b1);
    chk("R7 empty window mutes", int'(mute_req), 1);

    // R7: saturation, 300 events against minimum 128
    restart();
    lo_cnt_code = 3'd7;
    for (int i = 0; i < 300; i++) step(1'b1, 16'd5, 1'b0);
    for (int i = 0; i < 50; i++) step(1'b0, '0, 1'b1);
    chk("R7 saturating low count keeps live", int'(mute_req), 0);

    // Random phase compared each cycle with the model (R2..R8)
    restart();
    for (int seg = 0; seg < 30; seg++) begin
      int vprob;
      int tprob;
      int amax;
      win_code = 3'($urandom_range(0, 2));
      lo_amp_code = 3'($urandom_range(0, 7));
      hi_amp_code = 3'($urandom_range(0, 7));
      lo_cnt_code = 3'($urandom_range(0, 7));
      hi_cnt_code = 3'($urandom_range(0, 3));
      vprob = $urandom_range(0, 100);
      tprob = $urandom_range(10, 100);
      amax = 3 * b_hi_lvl(hi_amp_code);
      for (int c = 0; c < 1500; c++) begin
        det_en = ($urandom_range(0, 999) != 0);
        step($urandom_range(0, 99) < vprob, 16'($urandom_range(0, amax)),
             $urandom_range(0, 99) < tprob);
        chk_model($sformatf("R5/R6 random seg %0d", seg));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule